// File: doc/BRIEF.md
# Instrument Bus Exerciser Pattern Generator

This block is a free-running diagnostic source for a parallel instrument bus that carries an 8-bit address, 8-bit data, a data-valid strobe and a poll strobe. While its enable input is high it drives a repeating, binary-weighted toggle pattern onto the address and data lines. It steps the two strobes in a fixed rhythm around that pattern, so a technician watching the lines can spot a stuck, shorted or badly timed line by eye.

The pattern is built from bus steps. A step is one data-valid low phase, in which the address may move, followed by one data-valid high phase, in which the data may move. Each phase lasts a parameterised number of clocks. A pattern period opens with a marker step: poll is high, the address is zero, and the upper data nibble pulses high. After the marker step come 256 counting steps in which the address and data both carry a count from 0 to 255. Bit 7 is the slowest line and bit 0 the fastest.

Dropping the enable takes effect only at the next step boundary. At that boundary every output returns to zero.

Top module: `ibx_exerciser`

## Requirements
- R1: While reset is low on a clock edge, all outputs (address, data, data-valid, poll) are zero after that edge.
- R2: Once running, each data-valid low phase and each high phase lasts exactly PHASE_CLKS clocks, and every step is one low phase followed by one high phase.
- R3: The address lines change only on the edge where data-valid falls. The data lines change only on the edge where data-valid rises, except for the return to all-zero on disable.
- R4: In counting step k of a period (k = 1..256), the address is k-1 for the whole step and the data is k-1 in the high phase. Bit 0 therefore completes 128 cycles per period, and each higher bit toggles at half the rate of the bit below it.
- R5: Step 0 of every period is the marker step. Poll is high for that whole step and low in every other step. The address is 0 in that step, and in its high phase the data is 0xF0: bits 7..4 are one and bits 3..0 are zero.
- R6: The step after counting step 256 is the marker step of the next period, and periods repeat for as long as enable stays high.
- R7: From idle, enable seen high on a clock edge starts the marker step at that edge. Poll goes high and data-valid stays low for PHASE_CLKS clocks.
- R8: Enable is sampled only at the end of a high phase. If it is low there, all outputs are zero after that edge. A low pulse on enable that ends before the boundary has no effect.
- R9: While idle with enable low, all outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run request, sampled at step boundaries |
| bus_addr | output | 8 | Pattern on the address lines |
| bus_data | output | 8 | Pattern on the data lines |
| bus_dv | output | 1 | Data-valid strobe |
| bus_poll | output | 1 | Poll strobe, high during the marker step |

## Verification
The assertions place no constraint on the enable input: the enable may change on any cycle, and the timing and marker properties must still hold. They do assume that reset is held low at time zero, so the phase-length counter and the previous-value registers begin from a known state. The stimulus drives enable and reset only at falling clock edges. It includes both an enable drop that spans a step boundary and a low pulse that ends before one, so both branches of the boundary sampling are exercised.

// File: rtl/ibx_pkg.sv
// Shared types for the instrument bus exerciser.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package ibx_pkg;

    // Strobe phase inside one bus step: address half, then data half.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } ibx_phase_e;

endpackage

// File: rtl/ibx_phase_timer.sv
// Counts PHASE_CLKS clocks per strobe phase and alternates address and
// data phases. Flags the last clock of each phase.
// Assumes: run is low while the generator is idle; the timer then
// restarts from the first clock of an address phase.
module ibx_phase_timer
    import ibx_pkg::*;
#(
    parameter int PHASE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic data_edge_o,
    output logic step_end_o
);
    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt;
    ibx_phase_e    phase;
    logic          last;

    // Last clock of the current phase.
    always_comb last = (cnt == LAST_CNT);

    // Phase clock counter and phase flip.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= PH_ADDR;
        end else if (last) begin
            cnt   <= '0;
            phase <= (phase == PH_ADDR) ? PH_DATA : PH_ADDR;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Boundary flags seen by the output stage.
    always_comb begin
        data_edge_o = run && last && (phase == PH_ADDR);
        step_end_o  = run && last && (phase == PH_DATA);
    end
endmodule

// File: rtl/ibx_step_seq.sv
// Step index within a pattern period: 0 is the marker step, 1..2**BUS_W
// are the counting steps. Wraps back to 0 after the last counting step.
// Assumes: adv is a one-clock pulse at each step boundary.
module ibx_step_seq #(
    parameter int BUS_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           adv,
    output logic [BUS_W:0] seq_o,
    output logic [BUS_W:0] seq_nxt_o
);
    localparam int SW = BUS_W + 1;
    localparam logic [SW-1:0] LAST_STEP = SW'(1) << BUS_W;

    // Next step index with wrap to the marker step.
    always_comb seq_nxt_o = (seq_o == LAST_STEP) ? '0 : seq_o + 1'b1;

    // Step index register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) seq_o <= '0;
        else if (adv)       seq_o <= seq_nxt_o;
    end
endmodule

// File: rtl/ibx_pattern_map.sv
// Maps a step index to the bus values for that step: the marker step
// gives address zero, poll high and the upper-nibble data pulse; the
// counting steps give index minus one on both address and data.
// Assumes: BUS_W is even so the nibble split is exact.
module ibx_pattern_map #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W:0]   seq_i,
    output logic [BUS_W-1:0] addr_o,
    output logic [BUS_W-1:0] data_o,
    output logic             poll_o
);
    localparam int HALF = BUS_W / 2;
    localparam logic [BUS_W-1:0] MARK_DATA =
        {{(BUS_W - HALF){1'b1}}, {HALF{1'b0}}};

    logic [BUS_W-1:0] count_val;

    // Value for counting steps and for the marker step.
    always_comb begin
        count_val = seq_i[BUS_W-1:0] - 1'b1;
        poll_o    = (seq_i == '0);
        addr_o    = poll_o ? '0 : count_val;
        data_o    = poll_o ? MARK_DATA : count_val;
    end
endmodule

// File: rtl/ibx_exerciser.sv
// Instrument bus exerciser top: registers the bus outputs, updating the
// address only as data-valid falls and the data only as it rises.
// Enable is honoured at step boundaries only.
// Assumes: en is synchronous to clk.
module ibx_exerciser #(
    parameter int BUS_W      = 8,
    parameter int PHASE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [BUS_W-1:0] bus_addr,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_dv,
    output logic             bus_poll
);
    localparam int SEQ_W = BUS_W + 1;

    logic             active;
    logic             data_edge;
    logic             step_end;
    logic [SEQ_W-1:0] seq;
    logic [SEQ_W-1:0] seq_nxt;
    logic [SEQ_W-1:0] map_in;
    logic [BUS_W-1:0] map_addr;
    logic [BUS_W-1:0] map_data;
    logic             map_poll;

    ibx_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (active),
        .data_edge_o (data_edge),
        .step_end_o  (step_end)
    );

    ibx_step_seq #(.BUS_W(BUS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .adv       (step_end),
        .seq_o     (seq),
        .seq_nxt_o (seq_nxt)
    );

    // Current step feeds the data update, the next step the address update.
    always_comb map_in = step_end ? seq_nxt : seq;

    ibx_pattern_map #(.BUS_W(BUS_W)) u_map (
        .seq_i  (map_in),
        .addr_o (map_addr),
        .data_o (map_data),
        .poll_o (map_poll)
    );

    // Output stage: start, data update, step boundary and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            bus_addr <= '0;
            bus_data <= '0;
            bus_dv   <= 1'b0;
            bus_poll <= 1'b0;
        end else if (!active) begin
            if (en) begin
                active   <= 1'b1;
                bus_addr <= '0;
                bus_dv   <= 1'b0;
                bus_poll <= 1'b1;
            end
        end else if (data_edge) begin
            bus_dv   <= 1'b1;
            bus_data <= map_data;
        end else if (step_end) begin
            if (!en) begin
                active   <= 1'b0;
                bus_addr <= '0;
                bus_data <= '0;
                bus_dv   <= 1'b0;
                bus_poll <= 1'b0;
            end else begin
                bus_dv   <= 1'b0;
                bus_addr <= map_addr;
                bus_poll <= map_poll;
            end
        end
    end
endmodule

// File: rtl/ibx_exerciser_chk.sv
// Protocol checker for the exerciser outputs, bound to the top module.
// Assumes: reset is low at time zero.
module ibx_exerciser_chk #(
    parameter int BUS_W      = 8,
    parameter int PHASE_CLKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_dv,
    input logic             bus_poll
);
    localparam logic [BUS_W-1:0] MARK_DATA =
        {{(BUS_W - BUS_W / 2){1'b1}}, {(BUS_W / 2){1'b0}}};

    logic        dv_q;
    logic        poll_q;
    logic [31:0] held;

    // Previous strobe values and clocks since the last strobe event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q   <= 1'b0;
            poll_q <= 1'b0;
            held   <= '0;
        end else begin
            dv_q   <= bus_dv;
            poll_q <= bus_poll;
            if ((bus_dv != dv_q) || (bus_poll && !poll_q)) held <= '0;
            else if (held != 32'hFFFF_FFFF)                held <= held + 1'b1;
        end
    end

    // R2: data-valid moves only after a full phase.
    assert_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dv != dv_q) |-> (held == 32'(PHASE_CLKS - 1)));

    // R3: address moves only as data-valid falls.
    assert_addr_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_addr) |-> $fell(bus_dv));

    // R3: data moves only as data-valid rises, or on return to idle.
    assert_data_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_data) |-> ($rose(bus_dv) ||
            (bus_data == '0 && bus_addr == '0 && !bus_dv && !bus_poll)));

    // R5: marker step carries address zero.
    assert_mark_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_poll |-> (bus_addr == '0));

    // R5: marker step high phase carries the upper-nibble pulse.
    assert_mark_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_poll && bus_dv) |-> (bus_data == MARK_DATA));

    // R5: poll moves only with data-valid low.
    assert_poll_low_dv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_poll) |-> !bus_dv);
endmodule

bind ibx_exerciser ibx_exerciser_chk #(
    .BUS_W      (BUS_W),
    .PHASE_CLKS (PHASE_CLKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_dv   (bus_dv),
    .bus_poll (bus_poll)
);

// File: tb/ibx_exerciser_tb.sv
// Directed bench for the instrument bus exerciser.
module ibx_exerciser_tb;
    localparam int P = 3;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] bus_addr;
    logic [W-1:0] bus_data;
    logic         bus_dv;
    logic         bus_poll;

    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] prev_data;

    ibx_exerciser #(.BUS_W(W), .PHASE_CLKS(P)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_dv   (bus_dv),
        .bus_poll (bus_poll)
    );

    always #4 clk = ~clk;

    // Record one check; outputs packed as {addr, data, dv, poll}.
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%05h expected=%05h", req, what, act, exp);
        end
    endtask

    // Check one whole step (2*P falling-edge samples); optionally move en.
    task automatic step_chk(input int k, input int en_low_at, input int en_high_at);
        logic [W-1:0] a_e;
        logic [W-1:0] d_hi;
        logic         p_e;
        logic [17:0]  exp_v;
        logic [17:0]  bad_v;
        logic [17:0]  bad_e;
        bit           ok;
        a_e  = (k == 0) ? '0 : W'(k - 1);
        d_hi = (k == 0) ? 8'hF0 : W'(k - 1);
        p_e  = (k == 0);
        ok   = 1'b1;
        bad_v = '0;
        bad_e = '0;
        for (int n = 0; n < 2 * P; n++) begin
            @(negedge clk);
            exp_v = (n < P) ? {a_e, prev_data, 1'b0, p_e} : {a_e, d_hi, 1'b1, p_e};
            if ({bus_addr, bus_data, bus_dv, bus_poll} !== exp_v && ok) begin
                ok    = 1'b0;
                bad_v = {bus_addr, bus_data, bus_dv, bus_poll};
                bad_e = exp_v;
            end
            if (n == en_low_at)  en = 1'b0;
            if (n == en_high_at) en = 1'b1;
        end
        prev_data = d_hi;
        // R2 R3 timing per phase; R5 marker step; R4 counting step.
        chk(ok, (k == 0) ? "R5" : "R4", $sformatf("R2 R3 step %0d", k), bad_v, bad_e);
    endtask

    // Expect all outputs zero for the given number of samples.
    task automatic zero_chk(input string req, input int cycles);
        bit          ok;
        logic [17:0] bad_v;
        ok = 1'b1;
        bad_v = '0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if ({bus_addr, bus_data, bus_dv, bus_poll} !== 18'h0 && ok) begin
                ok = 1'b0;
                bad_v = {bus_addr, bus_data, bus_dv, bus_poll};
            end
        end
        chk(ok, req, "outputs idle", bad_v, 18'h0);
    endtask

    // R1 R9: reset state, then idle with en low.
    task automatic t_reset();
        rst_n = 1'b0;
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk({bus_addr, bus_data, bus_dv, bus_poll} === 18'h0, "R1", "reset outputs",
            {bus_addr, bus_data, bus_dv, bus_poll}, 18'h0);
        rst_n = 1'b1;
        zero_chk("R9", 10);
    endtask

    // R7 R4 R5 R6: start from idle and run two complete periods.
    task automatic t_periods();
        prev_data = '0;
        en = 1'b1;
        for (int k = 0; k <= 256; k++) step_chk(k, -1, -1);
        // R6: next period begins with the marker step again.
        for (int k = 0; k <= 256; k++) step_chk(k, -1, -1);
    endtask

    // R8: short low pulse on en is ignored, a held low stops at the boundary.
    task automatic t_disable();
        step_chk(0, -1, -1);
        step_chk(1, 1, P);      // R8 pulse ends before boundary: ignored
        step_chk(2, -1, -1);
        step_chk(3, P + 1, -1); // R8 low at boundary: stop
        zero_chk("R8", 4 * P);
    endtask

    // R7: restart after stop begins with the marker step.
    task automatic t_restart();
        prev_data = '0;
        en = 1'b1;
        step_chk(0, -1, -1);
        step_chk(1, -1, -1);
        step_chk(2, 2 * P - 1, -1);
        zero_chk("R9", 2 * P);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_periods();
        t_disable();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule